// File: doc/BRIEF.md
# Register-Mapped Transaction Message Port

This block connects a processor on a plain 32-bit register bus with a link that carries 64-bit transaction words. The processor first writes a data word into a staging register. It then writes a control word, and the block sends the pair as a single outbound transaction. The control word sits in the upper half of the transaction and the staged data in the lower half. The control word uses flags for its type: read response (bit 31), write request (bit 30), read request (bit 29) and half-word cycle (bit 28). Bits 19:0 hold the address.

Inbound traffic comes on two separate inputs. A request word from the remote host is captured and held until software has read it. While it is held, the block deasserts its ready so that no further request can overwrite it. The data returned for a read that the block sent out is captured in a response register. A status word gathers the outstanding-read, pending-request, pending-response and busy conditions, so that software can poll them.

Top module: `msgport`

## Requirements
- R1: After reset, status reads 0, register 2 reads 0, `out_valid` is 0 and `in_req_ready` is 1.
- R2: A write to register 0 followed by a write to register 1 with value C makes `out_valid` high in the cycle after the control write, with `out_word` = {C, staged data}. Status bit 4 (busy) is 1 from then until the word is accepted.
- R3: While `out_valid` is high and `out_ready` is low, `out_word` holds steady. In the cycle after the `out_valid && out_ready` handshake, `out_valid` and busy are 0.
- R4: A register-1 write made while busy is ignored: no extra transaction is sent and `out_word` does not change. A register-0 write made while busy only changes the staged data for the next transaction.
- R5: An inbound request is captured on `in_req_valid && in_req_ready`. From the next cycle, status bit 1 is 1, `in_req_ready` is 0, register 0 reads the word's bits 31:0 and register 1 reads its bits 63:32. Requests offered while bit 1 is set do not replace the held word.
- R6: A read of register 1 (`reg_rd_en` high, address 1) clears status bit 1 and raises `in_req_ready` again. A read of register 0 clears nothing.
- R7: When an outbound word with control bit 29 (read request) is accepted, status bit 0 (read pending) is 1 from the next cycle.
- R8: A pulse on `rsp_valid` loads `rsp_data` into register 2, clears status bit 0 and sets status bit 2 from the next cycle. A read of register 2 clears status bit 2.
- R9: When a response arrives in the same cycle as a read-request handshake, bit 0 stays set and the response is still captured. When a response arrives in the same cycle as a register-2 read, the read returns the old value and bit 2 stays set.
- R10: A control word with only bit 31 (read response) set goes out as {0x80000000, staged data}. This is the reply to a remote read.
- R11: Writes to registers 2 and 3 change no register contents and send no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (needed for read side effects) |
| reg_addr | input | 2 | Register index 0..3 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| out_valid | output | 1 | Outbound transaction valid |
| out_ready | input | 1 | Downstream accepts outbound word |
| out_word | output | 64 | Outbound transaction {control, data} |
| in_req_valid | input | 1 | Inbound request valid |
| in_req_ready | output | 1 | Block can take an inbound request |
| in_req_word | input | 64 | Inbound request {control, data} |
| rsp_valid | input | 1 | Read-response data valid |
| rsp_data | input | 32 | Read-response data |

## Verification
Two pairs of functions can fall in the same cycle: the return of read data with the handshake of a new read request, and the return of read data with a software read of the response register. The bench forces each pair into a single clock edge. It does this by holding `out_ready` low until the response pulse is raised, and by driving the register-2 read strobe in the same cycle as the pulse. It then judges the result from the status bits after the edge and from the old and new contents of register 2.

// File: rtl/msgport_pkg.sv
package msgport_pkg;
    localparam int IDX_DATA = 0;
    localparam int IDX_CTRL = 1;
    localparam int IDX_RESP = 2;
    localparam int IDX_STAT = 3;

    localparam int FLG_READ_RESP = 31;
    localparam int FLG_WRITE_REQ = 30;
    localparam int FLG_READ_REQ  = 29;
    localparam int FLG_HALF_WORD = 28;

    localparam int ST_READ_PEND = 0;
    localparam int ST_REQ_PEND  = 1;
    localparam int ST_RSP_PEND  = 2;
    localparam int ST_BUSY      = 4;
endpackage

// File: rtl/msgport_tx.sv
module msgport_tx #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_wr,
    input  logic                ctrl_wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*DATA_W-1:0] out_word,
    output logic                read_issued
);
    import msgport_pkg::*;
    localparam int WORD_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [WORD_W-1:0] word;
        logic              busy;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_wr) st_d.stage = wdata;
        if (st_q.busy && out_ready) st_d.busy = 1'b0;
        if (ctrl_wr && !st_q.busy) begin
            st_d.word = {wdata, st_q.stage};
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.busy;
    assign out_word    = st_q.word;
    assign read_issued = st_q.busy && out_ready && st_q.word[DATA_W + FLG_READ_REQ];

    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !out_valid |=> out_valid);
    p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word));
    p_drop_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid);
endmodule

// File: rtl/msgport_req.sv
module msgport_req #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_req_valid,
    input  logic [2*DATA_W-1:0] in_req_word,
    input  logic                ctrl_rd,
    output logic                in_req_ready,
    output logic                req_pend,
    output logic [2*DATA_W-1:0] req_word
);
    localparam int WORD_W = 2 * DATA_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pend;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_rd) st_d.pend = 1'b0;
        if (in_req_valid && !st_q.pend) begin
            st_d.word = in_req_word;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_req_ready = !st_q.pend;
    assign req_pend     = st_q.pend;
    assign req_word     = st_q.word;

    p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_req_valid && in_req_ready |=> req_pend && !in_req_ready && (req_word == $past(in_req_word)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_pend && !ctrl_rd |=> req_pend && $stable(req_word));
endmodule

// File: rtl/msgport_rsp.sv
module msgport_rsp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              read_issued,
    input  logic              resp_rd,
    output logic              rd_pend,
    output logic              rsp_pend,
    output logic [DATA_W-1:0] rsp_word
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              rd_pend;
        logic              rsp_pend;
    } rsp_state_t;

    rsp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a newly issued read outranks the response to an older one
        if (rsp_valid)   st_d.rd_pend = 1'b0;
        if (read_issued) st_d.rd_pend = 1'b1;
        // a new arrival outranks the software read of the old one
        if (resp_rd)     st_d.rsp_pend = 1'b0;
        if (rsp_valid) begin
            st_d.rsp_pend = 1'b1;
            st_d.data     = rsp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_pend  = st_q.rd_pend;
    assign rsp_pend = st_q.rsp_pend;
    assign rsp_word = st_q.data;

    p_read_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        read_issued |=> rd_pend);
    p_rsp_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> rsp_pend && (rsp_word == $past(rsp_data)));
    p_rdpend_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_pend) |-> $past(rsp_valid));
endmodule

// File: rtl/msgport.sv
module msgport #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [2*DATA_W-1:0] out_word,
    input  logic                in_req_valid,
    output logic                in_req_ready,
    input  logic [2*DATA_W-1:0] in_req_word,
    input  logic                rsp_valid,
    input  logic [DATA_W-1:0]   rsp_data
);
    import msgport_pkg::*;
    localparam int WORD_W = 2 * DATA_W;

    logic data_wr, ctrl_wr, ctrl_rd, resp_rd;
    logic read_issued, req_pend, rd_pend, rsp_pend;
    logic [WORD_W-1:0] req_word;
    logic [DATA_W-1:0] rsp_word;
    logic [DATA_W-1:0] status;

    assign data_wr = reg_wr_en && (reg_addr == 2'(IDX_DATA));
    assign ctrl_wr = reg_wr_en && (reg_addr == 2'(IDX_CTRL));
    assign ctrl_rd = reg_rd_en && (reg_addr == 2'(IDX_CTRL));
    assign resp_rd = reg_rd_en && (reg_addr == 2'(IDX_RESP));

    msgport_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
        .wdata(reg_wdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .read_issued(read_issued)
    );

    msgport_req #(.DATA_W(DATA_W)) u_req (
        .clk(clk), .rst_n(rst_n), .in_req_valid(in_req_valid),
        .in_req_word(in_req_word), .ctrl_rd(ctrl_rd),
        .in_req_ready(in_req_ready), .req_pend(req_pend), .req_word(req_word)
    );

    msgport_rsp #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .read_issued(read_issued), .resp_rd(resp_rd), .rd_pend(rd_pend),
        .rsp_pend(rsp_pend), .rsp_word(rsp_word)
    );

    always_comb begin
        status               = '0;
        status[ST_READ_PEND] = rd_pend;
        status[ST_REQ_PEND]  = req_pend;
        status[ST_RSP_PEND]  = rsp_pend;
        status[ST_BUSY]      = out_valid;
    end

    always_comb begin
        unique case (reg_addr)
            2'(IDX_DATA): reg_rdata = req_word[DATA_W-1:0];
            2'(IDX_CTRL): reg_rdata = req_word[WORD_W-1:DATA_W];
            2'(IDX_RESP): reg_rdata = rsp_word;
            default:      reg_rdata = status;
        endcase
    end

    p_ready_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd && !in_req_valid |=> in_req_ready);
    p_rsp_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_rd && !rsp_valid |=> !rsp_pend);
endmodule

// File: tb/tb_msgport.sv
module tb_msgport;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        out_valid, out_ready = 1'b1;
    logic [63:0] out_word;
    logic        in_req_valid = 1'b0, in_req_ready;
    logic [63:0] in_req_word = '0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    int vectors = 0, misses = 0;
    bit done = 0;
    logic [63:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msgport dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .in_req_valid(in_req_valid), .in_req_ready(in_req_ready),
        .in_req_word(in_req_word), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic send(logic [31:0] ctrl, logic [31:0] staged);
        expq.push_back({ctrl, staged});
        wr(2'd1, ctrl);
    endtask

    // monitor: samples late in the low phase, i.e. the handshake of the coming edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && out_valid && out_ready) begin
                if (expq.size() == 0) chk("R4 unexpected transaction", out_word, 64'hx);
                else chk("R2 outbound word", out_word, expq.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd3, v); chk("R1 status", v, 0);
        peek(2'd2, v); chk("R1 resp reg", v, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_req_ready", in_req_ready, 1);

        // R2 plain write transaction
        wr(2'd0, 32'h1234_5678);
        send(32'h4000_0ABC, 32'h1234_5678);
        chk("R2 out_valid", out_valid, 1);
        peek(2'd3, v); chk("R2 busy", v, 32'h10);
        @(negedge clk);
        peek(2'd3, v); chk("R3 busy clear", v, 0);

        // R3/R4 backpressure and ignored control write
        out_ready = 1'b0;
        wr(2'd0, 32'hAAAA_0001);
        send(32'h4000_0010, 32'hAAAA_0001);
        repeat (3) @(negedge clk);
        chk("R3 held valid", out_valid, 1);
        chk("R3 held word", out_word, {32'h4000_0010, 32'hAAAA_0001});
        wr(2'd0, 32'hBBBB_0002);
        wr(2'd1, 32'h4000_0020);
        chk("R4 word unchanged", out_word, {32'h4000_0010, 32'hAAAA_0001});
        out_ready = 1'b1;
        @(negedge clk);
        chk("R3 valid drops", out_valid, 0);
        peek(2'd3, v); chk("R3 status", v, 0);
        send(32'h4000_0030, 32'hBBBB_0002);   // R4: staged while busy
        @(negedge clk);

        // R7 read request sets read pending
        send(32'h2000_0100, 32'hBBBB_0002);
        @(negedge clk);
        peek(2'd3, v); chk("R7 read pending", v, 32'h1);

        // R8 response capture and clear
        rsp_valid = 1'b1; rsp_data = 32'hD00D_0001;
        @(negedge clk);
        rsp_valid = 1'b0;
        peek(2'd3, v); chk("R8 status after rsp", v, 32'h4);
        rd(2'd2, v); chk("R8 resp data", v, 32'hD00D_0001);
        peek(2'd3, v); chk("R8 status cleared", v, 0);

        // R9a response and read handshake in one edge
        out_ready = 1'b0;
        send(32'h2000_0200, 32'hBBBB_0002);
        out_ready = 1'b1; rsp_valid = 1'b1; rsp_data = 32'hD00D_0002;
        @(negedge clk);
        rsp_valid = 1'b0;
        peek(2'd3, v); chk("R9 both bits set", v, 32'h5);
        peek(2'd2, v); chk("R9 resp captured", v, 32'hD00D_0002);

        // R9b register-2 read and response in one edge
        @(negedge clk);
        reg_addr = 2'd2; reg_rd_en = 1'b1; rsp_valid = 1'b1; rsp_data = 32'hD00D_0003;
        #1 chk("R9 old value read", reg_rdata, 32'hD00D_0002);
        @(negedge clk);
        reg_rd_en = 1'b0; rsp_valid = 1'b0;
        peek(2'd3, v); chk("R9 rsp pend kept", v, 32'h4);
        peek(2'd2, v); chk("R9 new value", v, 32'hD00D_0003);
        rd(2'd2, v);
        peek(2'd3, v); chk("R8 status clear again", v, 0);

        // R10 read-response reply
        wr(2'd0, 32'h0BAD_F00D);
        send(32'h8000_0000, 32'h0BAD_F00D);
        @(negedge clk);

        // R5/R6 inbound request
        in_req_valid = 1'b1; in_req_word = {32'h4000_0044, 32'hCAFE_0001};
        @(negedge clk);
        in_req_word = {32'h2000_0055, 32'hCAFE_0002};
        peek(2'd3, v); chk("R5 req pending", v, 32'h2);
        chk("R5 ready low", in_req_ready, 0);
        repeat (2) @(negedge clk);
        in_req_valid = 1'b0;
        rd(2'd0, v); chk("R5 data half", v, 32'hCAFE_0001);
        peek(2'd3, v); chk("R6 data read keeps pending", v, 32'h2);
        rd(2'd1, v); chk("R5 control half", v, 32'h4000_0044);
        peek(2'd3, v); chk("R6 pending cleared", v, 0);
        chk("R6 ready back", in_req_ready, 1);

        // R11 writes to read-only registers
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        peek(2'd2, v); chk("R11 resp unchanged", v, 32'hD00D_0003);
        peek(2'd3, v); chk("R11 status unchanged", v, 0);

        repeat (4) @(negedge clk);
        chk("R4 all expected sent", 64'(expq.size()), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule